// File: doc/BRIEF.md
# Two-Width Sequential Unsigned Divider

This block divides unsigned integers over several clock cycles in one of two widths. In narrow mode it divides a 16-bit dividend by a 16-bit divisor. In wide mode it divides a 32-bit dividend by a 32-bit divisor. Wide operands arrive as an upper and a lower 16-bit half on separate ports. The quotient and remainder leave the same way. A processor core uses it as the execution unit for its unsigned divide operations. The core pulses `start` with the operands and the mode, then takes the results when `done` pulses.

Every divide in a mode takes the same number of cycles, whatever the data. Narrow mode takes 9 clocks and wide mode takes 17. A zero divisor does not trap. It finishes in the normal time, with an all-ones quotient of the mode's width and a remainder equal to the dividend. The result ports keep their values from one completion until the next.

Top module: `seqdiv_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are 0 and all four result halves are 0 until the first completion.
- R2: With `wide_mode` = 0, `quo_lo` = `dvd_lo` / `dvs_lo` and `rem_lo` = `dvd_lo` mod `dvs_lo`. `quo_hi` and `rem_hi` read 0, and the values on `dvd_hi` and `dvs_hi` have no effect on the result. The remainder is always below a nonzero divisor.
- R3: With `wide_mode` = 1, the dividend is {`dvd_hi`,`dvd_lo`} and the divisor is {`dvs_hi`,`dvs_lo`}. The results are {`quo_hi`,`quo_lo`} = quotient and {`rem_hi`,`rem_lo`} = remainder.
- R4: A zero divisor yields a quotient of all ones over the mode's width (0xFFFF in narrow mode, 0xFFFFFFFF in wide mode) and a remainder equal to the dividend.
- R5: In narrow mode, `done` is high in the cycle that follows the 9th rising edge after the edge that accepted `start`. `busy` is high from the accepting edge until that 9th edge.
- R6: In wide mode, the same rule holds with 17 edges in place of 9.
- R7: `done` lasts exactly one cycle, and `busy` is 0 while `done` is 1.
- R8: A `start` seen while `busy` is 1 has no effect. The running divide keeps its operands, its mode and its completion time.
- R9: The result ports change only at a completion. They hold their values through the following idle cycles and through the next divide until it completes.
- R10: The completion time depends only on the mode. A zero divisor or a zero dividend finishes in the same number of cycles as any other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a divide; taken only when not busy |
| wide_mode | input | 1 | 0: 16-bit divide, 1: 32-bit divide |
| dvd_hi | input | 16 | Upper dividend half (wide mode only) |
| dvd_lo | input | 16 | Lower dividend half |
| dvs_hi | input | 16 | Upper divisor half (wide mode only) |
| dvs_lo | input | 16 | Lower divisor half |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| quo_hi | output | 16 | Upper quotient half (0 in narrow mode) |
| quo_lo | output | 16 | Lower quotient half |
| rem_hi | output | 16 | Upper remainder half (0 in narrow mode) |
| rem_lo | output | 16 | Lower remainder half |

## Verification
The bench builds the block with its default parameters: a 32-bit full width split into 16-bit halves, and two quotient bits per iteration. This gives the fixed 9-clock and 17-clock latencies, so every cycle of both modes' timing is checked exactly. Random operands, including small divisors and junk on the unused upper halves, cover carries through both halves of the partial remainder. Directed cases cover the zero divisor, the all-ones extremes, a dividend smaller than its divisor, and a `start` issued mid-operation.

// File: rtl/seqdiv_pkg.sv
// Package seqdiv_pkg
// Shared definitions for the sequential divider: the width mode type.
// Assumes nothing beyond standard SystemVerilog.
package seqdiv_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } div_mode_e;

endpackage

// File: rtl/seqdiv_step.sv
// Module seqdiv_step
// One restoring division step, purely combinational. It shifts the next
// dividend bit into the partial remainder, subtracts the divisor when that
// leaves no borrow, and shifts the resulting quotient bit into q_out.
// Assumes p_in < d_in whenever d_in is nonzero.
module seqdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] p_out,
    output logic [W-1:0] q_out
);

    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    // Compare the shifted partial remainder with the divisor and pick the restored or reduced value.
    always_comb begin
        shifted = {p_in, q_in[W-1]};
        diff    = shifted - {1'b0, d_in};
        fits    = (shifted >= {1'b0, d_in});
        p_out   = fits ? diff[W-1:0] : shifted[W-1:0];
        q_out   = {q_in[W-2:0], fits};
    end

endmodule

// File: rtl/seqdiv_ctrl.sv
// Module seqdiv_ctrl
// Sequencer for the divider. It accepts start only while idle, loads an
// iteration count from the mode, runs one iteration per cycle, then spends
// one cycle on write-back and pulses done in the cycle that follows.
// Assumes STEP divides W/2 evenly.
module seqdiv_ctrl
    import seqdiv_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  div_mode_e mode,
    output logic      busy,
    output logic      done,
    output logic      load,
    output logic      step_en,
    output logic      finish
);

    localparam int NARROW_STEPS = (W / 2) / STEP;
    localparam int WIDE_STEPS   = W / STEP;
    localparam int CW           = $clog2(WIDE_STEPS + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    // Decode the current phase from the busy flag and the remaining count.
    always_comb begin
        load    = start && !busy_q;
        step_en = busy_q && (cnt_q != '0);
        finish  = busy_q && (cnt_q == '0);
    end

    // Advance the sequencer: load the count, count down, then end the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= (mode == MODE_WIDE) ? CW'(WIDE_STEPS) : CW'(NARROW_STEPS);
            end else if (step_en) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // Checker state: edges since acceptance and the accepted mode.
    logic [CW:0] chk_lat_q;
    div_mode_e   chk_mode_q;

    // Track the elapsed edges of the current operation for the latency checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_lat_q  <= '0;
            chk_mode_q <= MODE_NARROW;
        end else if (load) begin
            chk_lat_q  <= '0;
            chk_mode_q <= mode;
        end else if (busy_q) begin
            chk_lat_q <= chk_lat_q + 1'b1;
        end
    end

    p_latency_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && chk_mode_q == MODE_NARROW |-> chk_lat_q == (CW+1)'(NARROW_STEPS + 1));

    p_latency_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && chk_mode_q == MODE_WIDE |-> chk_lat_q == (CW+1)'(WIDE_STEPS + 1));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/seqdiv_core.sv
// Module seqdiv_core
// Datapath of the divider. It holds the partial remainder, the dividend /
// quotient shift register and the divisor, and retires STEP quotient bits
// per iteration through a chain of restoring steps. At finish it writes the
// results into output registers that hold until the next finish. A zero
// divisor needs no special path: every step then sets its quotient bit, and
// the dividend passes into the remainder unchanged.
// Assumes load, step_en and finish are mutually exclusive.
module seqdiv_core
    import seqdiv_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_en,
    input  logic          finish,
    input  div_mode_e     mode,
    input  logic [W/2-1:0] dvd_hi,
    input  logic [W/2-1:0] dvd_lo,
    input  logic [W/2-1:0] dvs_hi,
    input  logic [W/2-1:0] dvs_lo,
    output logic [W/2-1:0] quo_hi,
    output logic [W/2-1:0] quo_lo,
    output logic [W/2-1:0] rem_hi,
    output logic [W/2-1:0] rem_lo
);

    localparam int H = W / 2;

    logic [W-1:0] p_q;
    logic [W-1:0] q_q;
    logic [W-1:0] d_q;
    div_mode_e    mode_q;

    logic [W-1:0] p_ch [0:STEP];
    logic [W-1:0] q_ch [0:STEP];

    assign p_ch[0] = p_q;
    assign q_ch[0] = q_q;

    // Chain STEP restoring steps so that each cycle retires STEP quotient bits.
    for (genvar g = 0; g < STEP; g++) begin : g_step
        seqdiv_step #(.W(W)) u_step (
            .p_in  (p_ch[g]),
            .q_in  (q_ch[g]),
            .d_in  (d_q),
            .p_out (p_ch[g+1]),
            .q_out (q_ch[g+1])
        );
    end

    // Load the operands at acceptance and iterate while the sequencer allows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            q_q    <= '0;
            d_q    <= '0;
            mode_q <= MODE_NARROW;
        end else if (load) begin
            p_q    <= '0;
            mode_q <= mode;
            if (mode == MODE_WIDE) begin
                q_q <= {dvd_hi, dvd_lo};
                d_q <= {dvs_hi, dvs_lo};
            end else begin
                q_q <= {dvd_lo, {H{1'b0}}};
                d_q <= {{H{1'b0}}, dvs_lo};
            end
        end else if (step_en) begin
            p_q <= p_ch[STEP];
            q_q <= q_ch[STEP];
        end
    end

    // Write the finished quotient and remainder to the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_hi <= '0;
            quo_lo <= '0;
            rem_hi <= '0;
            rem_lo <= '0;
        end else if (finish) begin
            quo_lo <= q_q[H-1:0];
            rem_lo <= p_q[H-1:0];
            quo_hi <= (mode_q == MODE_WIDE) ? q_q[W-1:H] : '0;
            rem_hi <= (mode_q == MODE_WIDE) ? p_q[W-1:H] : '0;
        end
    end

    p_rem_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        finish && d_q != '0 |-> p_q < d_q);

    p_narrow_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        finish && mode_q == MODE_NARROW |=> quo_hi == '0 && rem_hi == '0);

    p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(quo_hi) && $stable(quo_lo) && $stable(rem_hi) && $stable(rem_lo));

endmodule

// File: rtl/seqdiv_unit.sv
// Module seqdiv_unit
// Top of the two-width sequential unsigned divider. It connects the
// sequencer and the datapath. Narrow mode divides 16 by 16 bits in 9
// clocks; wide mode divides 32 by 32 bits in 17 clocks (default parameters).
// Assumes W is even and STEP divides W/2.
module seqdiv_unit
    import seqdiv_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           wide_mode,
    input  logic [W/2-1:0] dvd_hi,
    input  logic [W/2-1:0] dvd_lo,
    input  logic [W/2-1:0] dvs_hi,
    input  logic [W/2-1:0] dvs_lo,
    output logic           busy,
    output logic           done,
    output logic [W/2-1:0] quo_hi,
    output logic [W/2-1:0] quo_lo,
    output logic [W/2-1:0] rem_hi,
    output logic [W/2-1:0] rem_lo
);

    div_mode_e mode;
    logic      load;
    logic      step_en;
    logic      finish;

    assign mode = div_mode_e'(wide_mode);

    seqdiv_ctrl #(.W(W), .STEP(STEP)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode    (mode),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step_en (step_en),
        .finish  (finish)
    );

    seqdiv_core #(.W(W), .STEP(STEP)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .finish  (finish),
        .mode    (mode),
        .dvd_hi  (dvd_hi),
        .dvd_lo  (dvd_lo),
        .dvs_hi  (dvs_hi),
        .dvs_lo  (dvs_lo),
        .quo_hi  (quo_hi),
        .quo_lo  (quo_lo),
        .rem_hi  (rem_hi),
        .rem_lo  (rem_lo)
    );

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: tb/seqdiv_unit_tb.sv
module seqdiv_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, dvs_hi = '0, dvs_lo = '0;
    logic        busy, done;
    logic [15:0] quo_hi, quo_lo, rem_hi, rem_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    seqdiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs_hi(dvs_hi), .dvs_lo(dvs_lo),
        .busy(busy), .done(done),
        .quo_hi(quo_hi), .quo_lo(quo_lo), .rem_hi(rem_hi), .rem_lo(rem_lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit wide, input logic [31:0] dvd, input logic [31:0] dvs,
                          input bit poke);
        logic [31:0] eq, er;
        logic [63:0] held;
        int lat, n;
        bit bad;
        string rreq, lreq;
        if (wide) begin
            eq = (dvs == 0) ? 32'hFFFF_FFFF : dvd / dvs;
            er = (dvs == 0) ? dvd : dvd % dvs;
            lat = 17;
            rreq = (dvs == 0) ? "R4" : "R3";
            lreq = (dvs == 0) ? "R10" : "R6";
        end else begin
            eq = {16'h0, (dvs[15:0] == 0) ? 16'hFFFF : dvd[15:0] / dvs[15:0]};
            er = {16'h0, (dvs[15:0] == 0) ? dvd[15:0] : dvd[15:0] % dvs[15:0]};
            lat = 9;
            rreq = (dvs[15:0] == 0) ? "R4" : "R2";
            lreq = (dvs[15:0] == 0) ? "R10" : "R5";
        end
        @(negedge clk);
        start = 1'b1; wide_mode = wide;
        {dvd_hi, dvd_lo} = dvd; {dvs_hi, dvs_lo} = dvs;
        @(negedge clk);
        start = 1'b0;
        {dvd_hi, dvd_lo} = $urandom; {dvs_hi, dvs_lo} = $urandom;
        n = 0; bad = 0;
        while (n < lat) begin
            if (!(busy && !done)) bad = 1;
            if (poke && n == 3) begin
                start = 1'b1; wide_mode = ~wide;
                {dvd_hi, dvd_lo} = $urandom; {dvs_hi, dvs_lo} = 32'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done && !busy && !bad, poke ? "R8" : lreq, "done timing",
            {62'h0, done, busy}, 64'h2);
        chk({quo_hi, quo_lo} == eq, poke ? "R8" : rreq, "quotient", {32'h0, quo_hi, quo_lo}, {32'h0, eq});
        chk({rem_hi, rem_lo} == er, poke ? "R8" : rreq, "remainder", {32'h0, rem_hi, rem_lo}, {32'h0, er});
        held = {quo_hi, quo_lo, rem_hi, rem_lo};
        @(negedge clk);
        chk(!done && !busy, "R7", "done one cycle", {62'h0, done, busy}, 64'h0);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk({quo_hi, quo_lo, rem_hi, rem_lo} == held, "R9", "results held",
            {quo_hi, quo_lo, rem_hi, rem_lo}, held);
    endtask

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7031));
        // R1: reset state, with start driven during reset
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1", "flags in reset", {62'h0, busy, done}, 64'h0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && {quo_hi, quo_lo, rem_hi, rem_lo} == 64'h0, "R1", "after reset",
            {quo_hi, quo_lo, rem_hi, rem_lo}, 64'h0);

        // Directed narrow cases (junk on the upper halves, R2)
        run_op(1'b0, 32'hA5A5_0064, 32'h5A5A_0007, 1'b0);
        run_op(1'b0, 32'h1234_FFFF, 32'hFFFF_0001, 1'b0);
        run_op(1'b0, 32'h0000_0003, 32'h0000_0009, 1'b0);
        run_op(1'b0, 32'hFFFF_0005, 32'h1234_0000, 1'b0);   // R4 narrow
        run_op(1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0);   // R10 zero/zero
        run_op(1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0);
        // Directed wide cases
        run_op(1'b1, 32'hFFFF_FFFF, 32'h0000_0003, 1'b0);
        run_op(1'b1, 32'h1234_5678, 32'h0000_0000, 1'b0);   // R4 wide
        run_op(1'b1, 32'h0001_0000, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b1, 32'h8000_0000, 32'h0001_0001, 1'b0);
        // R8: start pulses while busy
        run_op(1'b0, 32'h0000_C350, 32'h0000_00FB, 1'b1);
        run_op(1'b1, 32'hDEAD_BEEF, 32'h0000_1234, 1'b1);

        // Random operands in both modes
        for (int i = 0; i < 150; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            case ($urandom_range(0, 3))
                0: b = b & 32'h0000_00FF;
                1: b = b & 32'h00FF_FFFF;
                2: b = (b & 32'hFFFF_0000) | 32'h0000_0001;
                default: ;
            endcase
            run_op(1'b1, a, b, 1'b0);
            run_op(1'b0, $urandom, ($urandom_range(0, 1) == 1) ? ($urandom & 32'hFFFF_000F) : $urandom, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule